// File: doc/BRIEF.md
# Stack CPU Next-Top-of-Stack Function Unit

This block works out the value that the top-of-stack register of a 16-bit Forth-style dual-stack processor takes next. A 4-bit selection code picks one of sixteen results. The candidates are plain operand moves, wrapping arithmetic, bitwise logic, comparisons that give a full-word mask, logical shifts whose amount wraps modulo the word width, and a word that packs both stack pointers together. The operands are the current top T, the cell below it N, the top of the return stack R, a word already fetched from memory, and the data-stack and return-stack pointers.

The function itself is combinational. A register stage on each side wraps it so that it can be timed and tested as a unit. An operation is offered by raising `op_en_i` with the operands. Its result appears on `res_o` two rising edges later, with `res_vld_o` high for one cycle. Between results, `res_o` keeps its last value.

Top module: `tos_alu_top`

## Requirements
- R1: An operation sampled with `op_en_i` high at a rising edge puts its result on `res_o` at the second rising edge after it, and `res_vld_o` is high for exactly the cycle that follows that edge. Operations may be offered on back-to-back cycles. While `rst_n` is low, `res_o` is 0 and `res_vld_o` is 0, without waiting for a clock edge.
- R2: The codes 0 to 6 give, in turn: T, N, T+N, T AND N, T OR N, T XOR N, NOT T.
- R3: Code 7 gives 16'hFFFF when N equals T and 16'h0000 otherwise.
- R4: Code 8 gives 16'hFFFF when N is less than T as two's-complement numbers and 16'h0000 otherwise. Equal values give 0.
- R5: Code 15 gives 16'hFFFF when N is less than T as unsigned numbers and 16'h0000 otherwise. Equal values give 0.
- R6: Code 9 shifts N right logically, filling with zeros, by T[3:0] places. T[15:4] has no effect on the result.
- R7: Code 13 shifts N left, filling with zeros, by T[3:0] places. T[15:4] has no effect on the result.
- R8: Code 10 gives N minus T, and code 2 gives T plus N. Both wrap modulo 2^16.
- R9: Code 11 gives R, and code 12 gives the memory word input.
- R10: Code 14 gives the return-stack pointer in bits 15:8 and the data-stack pointer in bits 7:0. Both are the values sampled together with the operation.
- R11: When `op_en_i` is low, the other inputs are ignored. `res_o` keeps its value, and `res_vld_o` goes low two edges after the last accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_en_i | input | 1 | Accept the operands and the selection at this edge |
| op_sel_i | input | 4 | Result selection code |
| top_i | input | 16 | Current top of the data stack (T) |
| nxt_i | input | 16 | Second cell of the data stack (N) |
| rtop_i | input | 16 | Top of the return stack (R) |
| mem_i | input | 16 | Word loaded from memory |
| dsp_i | input | 8 | Data-stack pointer |
| rsp_i | input | 8 | Return-stack pointer |
| res_o | output | 16 | Next top-of-stack value |
| res_vld_o | output | 1 | The result on `res_o` was loaded at the last edge |

## Verification
The bench builds the unit with its defaults: a 16-bit word and 8-bit stack pointers. At these values the two pointers exactly fill the packed depth word, so both bytes of that word are checked with no padding. A 4-bit shift amount reaches both the zero shift and the fifteen-place shift. With these widths the sign bit and the unsigned borrow disagree on operand pairs such as 16'h8000 against 16'h7FFF, so the signed and unsigned comparisons can each be seen to fail in a different way.

// File: rtl/tos_pkg.sv
package tos_pkg;

  typedef enum logic [3:0] {
    SEL_T     = 4'd0,
    SEL_N     = 4'd1,
    SEL_ADD   = 4'd2,
    SEL_AND   = 4'd3,
    SEL_OR    = 4'd4,
    SEL_XOR   = 4'd5,
    SEL_INV   = 4'd6,
    SEL_EQ    = 4'd7,
    SEL_SLT   = 4'd8,
    SEL_SHR   = 4'd9,
    SEL_SUB   = 4'd10,
    SEL_RTOP  = 4'd11,
    SEL_MEM   = 4'd12,
    SEL_SHL   = 4'd13,
    SEL_DEPTH = 4'd14,
    SEL_ULT   = 4'd15
  } tos_sel_e;

endpackage

// File: rtl/tos_rst_sync.sv
module tos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/tos_shifter.sv
module tos_shifter #(
  parameter int DW   = 16,
  parameter bit LEFT = 1'b0,
  localparam int SW  = $clog2(DW)
) (
  input  logic [DW-1:0] val_i,
  input  logic [SW-1:0] amt_i,
  output logic [DW-1:0] res_o
);

  logic [DW-1:0] stage [SW+1];

  assign stage[0] = val_i;

  for (genvar g = 0; g < SW; g++) begin : g_stage
    localparam int DIST = 1 << g;
    logic [DW-1:0] moved;
    if (LEFT) begin : g_left
      assign moved = {stage[g][DW-1-DIST:0], {DIST{1'b0}}};
    end else begin : g_right
      assign moved = {{DIST{1'b0}}, stage[g][DW-1:DIST]};
    end
    assign stage[g+1] = amt_i[g] ? moved : stage[g];
  end

  assign res_o = stage[SW];

endmodule

// File: rtl/tos_arith.sv
module tos_arith #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] n_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] diff_o,
  output logic          eq_o,
  output logic          slt_o,
  output logic          ult_o
);

  logic [DW:0] wide_diff;
  logic        sign_split;

  always_comb begin
    sum_o      = n_i + t_i;
    wide_diff  = {1'b0, n_i} - {1'b0, t_i};
    diff_o     = wide_diff[DW-1:0];
    ult_o      = wide_diff[DW];
    eq_o       = (diff_o == '0);
    sign_split = n_i[DW-1] ^ t_i[DW-1];
    slt_o      = sign_split ? n_i[DW-1] : diff_o[DW-1];
  end

endmodule

// File: rtl/tos_select.sv
module tos_select
  import tos_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 8
) (
  input  tos_sel_e      sel_i,
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] n_i,
  input  logic [DW-1:0] r_i,
  input  logic [DW-1:0] m_i,
  input  logic [PW-1:0] dsp_i,
  input  logic [PW-1:0] rsp_i,
  input  logic [DW-1:0] sum_i,
  input  logic [DW-1:0] diff_i,
  input  logic          eq_i,
  input  logic          slt_i,
  input  logic          ult_i,
  input  logic [DW-1:0] shr_i,
  input  logic [DW-1:0] shl_i,
  output logic [DW-1:0] next_o
);

  localparam int PACKW = 2 * PW;

  logic [PACKW-1:0] sp_pair;
  logic [DW-1:0]    depth_word;

  assign sp_pair = {rsp_i, dsp_i};

  if (PACKW >= DW) begin : g_pack_trim
    assign depth_word = sp_pair[DW-1:0];
  end else begin : g_pack_pad
    assign depth_word = {{(DW-PACKW){1'b0}}, sp_pair};
  end

  always_comb begin
    unique case (sel_i)
      SEL_T:     next_o = t_i;
      SEL_N:     next_o = n_i;
      SEL_ADD:   next_o = sum_i;
      SEL_AND:   next_o = t_i & n_i;
      SEL_OR:    next_o = t_i | n_i;
      SEL_XOR:   next_o = t_i ^ n_i;
      SEL_INV:   next_o = ~t_i;
      SEL_EQ:    next_o = {DW{eq_i}};
      SEL_SLT:   next_o = {DW{slt_i}};
      SEL_SHR:   next_o = shr_i;
      SEL_SUB:   next_o = diff_i;
      SEL_RTOP:  next_o = r_i;
      SEL_MEM:   next_o = m_i;
      SEL_SHL:   next_o = shl_i;
      SEL_DEPTH: next_o = depth_word;
      SEL_ULT:   next_o = {DW{ult_i}};
      default:   next_o = t_i;
    endcase
  end

endmodule

// File: rtl/tos_alu_top.sv
module tos_alu_top
  import tos_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_en_i,
  input  logic [3:0]    op_sel_i,
  input  logic [DW-1:0] top_i,
  input  logic [DW-1:0] nxt_i,
  input  logic [DW-1:0] rtop_i,
  input  logic [DW-1:0] mem_i,
  input  logic [PW-1:0] dsp_i,
  input  logic [PW-1:0] rsp_i,
  output logic [DW-1:0] res_o,
  output logic          res_vld_o
);

  logic rst_q_n;

  tos_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // operand stage
  tos_sel_e      sel_q,  sel_d;
  logic [DW-1:0] t_q,    t_d;
  logic [DW-1:0] n_q,    n_d;
  logic [DW-1:0] r_q,    r_d;
  logic [DW-1:0] m_q,    m_d;
  logic [PW-1:0] dsp_q,  dsp_d;
  logic [PW-1:0] rsp_q,  rsp_d;
  logic          opv_q,  opv_d;

  always_comb begin
    sel_d = sel_q;
    t_d   = t_q;
    n_d   = n_q;
    r_d   = r_q;
    m_d   = m_q;
    dsp_d = dsp_q;
    rsp_d = rsp_q;
    opv_d = op_en_i;
    if (op_en_i) begin
      sel_d = tos_sel_e'(op_sel_i);
      t_d   = top_i;
      n_d   = nxt_i;
      r_d   = rtop_i;
      m_d   = mem_i;
      dsp_d = dsp_i;
      rsp_d = rsp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_q <= SEL_T;
      t_q   <= '0;
      n_q   <= '0;
      r_q   <= '0;
      m_q   <= '0;
      dsp_q <= '0;
      rsp_q <= '0;
      opv_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      t_q   <= t_d;
      n_q   <= n_d;
      r_q   <= r_d;
      m_q   <= m_d;
      dsp_q <= dsp_d;
      rsp_q <= rsp_d;
      opv_q <= opv_d;
    end
  end

  // function core
  logic [DW-1:0] sum_w, diff_w, shr_w, shl_w, next_w;
  logic          eq_w, slt_w, ult_w;

  tos_arith #(.DW(DW)) arith_i (
    .t_i    (t_q),
    .n_i    (n_q),
    .sum_o  (sum_w),
    .diff_o (diff_w),
    .eq_o   (eq_w),
    .slt_o  (slt_w),
    .ult_o  (ult_w)
  );

  tos_shifter #(.DW(DW), .LEFT(1'b0)) shr_i (
    .val_i (n_q),
    .amt_i (t_q[SW-1:0]),
    .res_o (shr_w)
  );

  tos_shifter #(.DW(DW), .LEFT(1'b1)) shl_i (
    .val_i (n_q),
    .amt_i (t_q[SW-1:0]),
    .res_o (shl_w)
  );

  tos_select #(.DW(DW), .PW(PW)) select_i (
    .sel_i  (sel_q),
    .t_i    (t_q),
    .n_i    (n_q),
    .r_i    (r_q),
    .m_i    (m_q),
    .dsp_i  (dsp_q),
    .rsp_i  (rsp_q),
    .sum_i  (sum_w),
    .diff_i (diff_w),
    .eq_i   (eq_w),
    .slt_i  (slt_w),
    .ult_i  (ult_w),
    .shr_i  (shr_w),
    .shl_i  (shl_w),
    .next_o (next_w)
  );

  // result stage
  logic [DW-1:0] res_d;
  logic          vld_d;

  always_comb begin
    res_d = res_o;
    vld_d = opv_q;
    if (opv_q) res_d = next_w;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      res_vld_o <= vld_d;
    end
  end

endmodule

// File: rtl/tos_alu_chk.sv
module tos_alu_chk #(
  parameter int DW = 16,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_en_i,
  input logic [3:0]    op_sel_i,
  input logic [DW-1:0] top_i,
  input logic [DW-1:0] nxt_i,
  input logic [PW-1:0] dsp_i,
  input logic [PW-1:0] rsp_i,
  input logic [DW-1:0] res_o,
  input logic          res_vld_o
);

  // R1: accepted operation yields a valid result two edges later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_en_i |=> ##1 res_vld_o);

  // R11: no accepted operation leaves the result untouched
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en_i |=> ##1 ($stable(res_o) && !res_vld_o));

  // R2: selection 0 passes T
  p_pass_t_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en_i && op_sel_i == 4'd0) |=> ##1 (res_o == $past(top_i, 2)));

  // R3: equality gives a full mask matching the comparison
  p_eq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en_i && op_sel_i == 4'd7) |=> ##1
      (res_o == {DW{$past(nxt_i, 2) == $past(top_i, 2)}}));

  // R5: unsigned compare yields only a full mask
  p_ult_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en_i && op_sel_i == 4'd15) |=> ##1 (res_o == '0 || res_o == '1));

  // R4: signed compare of equal operands is false
  p_slt_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en_i && op_sel_i == 4'd8 && top_i == nxt_i) |=> ##1 (res_o == '0));

  // R6: a right shift by a multiple of the width leaves N intact
  p_shr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en_i && op_sel_i == 4'd9 && top_i[3:0] == 4'd0) |=> ##1
      (res_o == $past(nxt_i, 2)));

  // R7: a left shift by a multiple of the width leaves N intact
  p_shl_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en_i && op_sel_i == 4'd13 && top_i[3:0] == 4'd0) |=> ##1
      (res_o == $past(nxt_i, 2)));

  // R10: packed pointers
  p_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en_i && op_sel_i == 4'd14) |=> ##1
      (res_o == {$past(rsp_i, 2), $past(dsp_i, 2)}));

endmodule

bind tos_alu_top tos_alu_chk #(.DW(DW), .PW(PW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .op_en_i   (op_en_i),
  .op_sel_i  (op_sel_i),
  .top_i     (top_i),
  .nxt_i     (nxt_i),
  .dsp_i     (dsp_i),
  .rsp_i     (rsp_i),
  .res_o     (res_o),
  .res_vld_o (res_vld_o)
);

// File: tb/tos_alu_tb_top.sv
`timescale 1ns/1ps
module tos_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_en_i = 1'b0;
  logic [3:0]  op_sel_i = '0;
  logic [15:0] top_i = '0, nxt_i = '0, rtop_i = '0, mem_i = '0;
  logic [7:0]  dsp_i = '0, rsp_i = '0;
  logic [15:0] res_o;
  logic        res_vld_o;

  always #2 clk = ~clk;

  tos_alu_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_en_i(op_en_i), .op_sel_i(op_sel_i),
    .top_i(top_i), .nxt_i(nxt_i), .rtop_i(rtop_i), .mem_i(mem_i),
    .dsp_i(dsp_i), .rsp_i(rsp_i), .res_o(res_o), .res_vld_o(res_vld_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  sel;
    logic [15:0] t;
    logic [15:0] n;
    logic [15:0] r;
    logic [15:0] m;
    logic [7:0]  d;
    logic [7:0]  p;
    logic [15:0] e;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{8'd2,  4'd0,  16'h1234, 16'h5678, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h1234}, // R2
    '{8'd2,  4'd1,  16'h1234, 16'h5678, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h5678}, // R2
    '{8'd8,  4'd2,  16'hFFFF, 16'h0002, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0001}, // R8
    '{8'd2,  4'd2,  16'h1234, 16'h1111, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h2345}, // R2
    '{8'd2,  4'd3,  16'hF0F0, 16'hFF00, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'hF000}, // R2
    '{8'd2,  4'd4,  16'hF0F0, 16'h0F00, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'hFFF0}, // R2
    '{8'd2,  4'd5,  16'hF0F0, 16'hFF00, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0FF0}, // R2
    '{8'd2,  4'd6,  16'h1234, 16'h0000, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'hEDCB}, // R2
    '{8'd3,  4'd7,  16'hABCD, 16'hABCD, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'hFFFF}, // R3
    '{8'd3,  4'd7,  16'hABCD, 16'hABCC, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0000}, // R3
    '{8'd4,  4'd8,  16'h0001, 16'hFFFF, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'hFFFF}, // R4
    '{8'd4,  4'd8,  16'hFFFF, 16'h0001, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0000}, // R4
    '{8'd4,  4'd8,  16'h8000, 16'h7FFF, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0000}, // R4
    '{8'd4,  4'd8,  16'h0005, 16'h0005, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0000}, // R4
    '{8'd5,  4'd15, 16'h0001, 16'hFFFF, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0000}, // R5
    '{8'd5,  4'd15, 16'hFFFF, 16'h0001, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'hFFFF}, // R5
    '{8'd5,  4'd15, 16'h8000, 16'h8000, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0000}, // R5
    '{8'd6,  4'd9,  16'h0004, 16'h8421, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0842}, // R6
    '{8'd6,  4'd9,  16'h0013, 16'hF000, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h1E00}, // R6
    '{8'd6,  4'd9,  16'hFFF0, 16'h8001, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h8001}, // R6
    '{8'd6,  4'd9,  16'h000F, 16'h8000, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0001}, // R6
    '{8'd7,  4'd13, 16'h0004, 16'h8421, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h4210}, // R7
    '{8'd7,  4'd13, 16'h0011, 16'h8001, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h0002}, // R7
    '{8'd7,  4'd13, 16'h000F, 16'h0003, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h8000}, // R7
    '{8'd8,  4'd10, 16'h0001, 16'h0000, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'hFFFF}, // R8
    '{8'd8,  4'd10, 16'h1000, 16'h3456, 16'h5A5A, 16'hA5A5, 8'h3C, 8'hC3, 16'h2456}, // R8
    '{8'd9,  4'd11, 16'h1111, 16'h2222, 16'hBEEF, 16'hA5A5, 8'h3C, 8'hC3, 16'hBEEF}, // R9
    '{8'd9,  4'd12, 16'h1111, 16'h2222, 16'h5A5A, 16'hCAFE, 8'h3C, 8'hC3, 16'hCAFE}, // R9
    '{8'd10, 4'd14, 16'h1111, 16'h2222, 16'h5A5A, 16'hA5A5, 8'h12, 8'h9A, 16'h9A12}, // R10
    '{8'd10, 4'd14, 16'h1111, 16'h2222, 16'h5A5A, 16'hA5A5, 8'hFF, 8'h00, 16'h00FF}  // R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_en_i  = 1'b1;
    op_sel_i = v.sel;
    top_i    = v.t;
    nxt_i    = v.n;
    rtop_i   = v.r;
    mem_i    = v.m;
    dsp_i    = v.d;
    rsp_i    = v.p;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    vec_t a, b, c;
    // R1 reset state
    #9;
    check("R1 reset res", res_o, 16'h0000);
    check("R1 reset vld", {15'd0, res_vld_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk); op_en_i = 1'b0;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", TBL[i].req, i), res_o, TBL[i].e);
      check($sformatf("R1 vld vec %0d", i), {15'd0, res_vld_o}, 16'h0001);
    end

    // R1 back-to-back stream
    a = TBL[3]; b = TBL[7]; c = TBL[26];
    @(negedge clk); drive(a);
    @(negedge clk); drive(b);
    @(negedge clk); check("R1 stream a", res_o, a.e); drive(c);
    @(negedge clk); check("R1 stream b", res_o, b.e); op_en_i = 1'b0;
    @(negedge clk); check("R1 stream c", res_o, c.e);
    check("R1 stream vld", {15'd0, res_vld_o}, 16'h0001);

    // R11 idle inputs ignored
    op_sel_i = 4'd0; top_i = 16'h7777; nxt_i = 16'h8888;
    rtop_i = 16'h9999; mem_i = 16'h4444;
    repeat (3) @(negedge clk);
    check("R11 hold res", res_o, c.e);
    check("R11 vld low", {15'd0, res_vld_o}, 16'h0000);

    // R6/R7 high shift bits ignored: 0x0F04 behaves as 4
    drive('{8'd6, 4'd9, 16'h0F04, 16'hF00F, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0F00});
    @(negedge clk); op_en_i = 1'b0;
    @(negedge clk); check("R6 high T bits", res_o, 16'h0F00);
    drive('{8'd7, 4'd13, 16'hA0F4, 16'hF00F, 16'h0, 16'h0, 8'h0, 8'h0, 16'h00F0});
    @(negedge clk); op_en_i = 1'b0;
    @(negedge clk); check("R7 high T bits", res_o, 16'h00F0);

    // R1 asynchronous reset mid-flight
    drive(TBL[0]);
    @(negedge clk); op_en_i = 1'b0;
    @(negedge clk); check("R1 pre-reset", res_o, 16'h1234);
    #0.5 rst_n = 1'b0;
    #0.5 check("R1 async reset res", res_o, 16'h0000);
    check("R1 async reset vld", {15'd0, res_vld_o}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    summary();
  end

endmodule